// File: doc/BRIEF.md
# Serial Binary Memory Loader

This block fills memory from a byte stream right after reset, before any user program runs. It takes bytes from a UART receiver that signals one byte per `rx_valid` strobe. The first four bytes form a header: a 16-bit destination address, then a 16-bit byte count, each sent low byte first. The bytes that follow are the payload. Each payload byte is written through a simple write port, starting at the destination address. The address steps up by one after every completed write. There is no terminator and no checksum.

The memory port may stall by holding `mem_ready` low. While it stalls, one more incoming byte is parked in a single-byte buffer. A byte that arrives while both the write stage and the buffer are full is lost, and a sticky error flag is set. When all counted bytes have been written, the loader raises `load_done` and drops `loader_busy`, which releases the memory port. After that it ignores the serial stream until `start` re-arms it.

Top module: `serial_loader`

## Requirements
- R1: After reset, `loader_busy`=1, `load_done`=0, `mem_we`=0 and `overrun_err`=0, and the loader waits for header bytes.
- R2: Header byte order is address bits 7:0, address bits 15:8, count bits 7:0, count bits 15:8. The first payload byte is written at the assembled address.
- R3: Payload bytes are written in arrival order at consecutive addresses. The address advances by one after each completed write and wraps from 16'hFFFF to 16'h0000.
- R4: A write completes in a cycle where `mem_we` and `mem_ready` are both 1. While `mem_ready` is 0, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R5: While the port stalls with a write pending, one further payload byte is kept and written after the pending one, with no loss.
- R6: A payload byte that arrives while both the pending write and the one-byte buffer are full is discarded and does not count toward the byte count. It sets `overrun_err`, which stays 1 until `start`.
- R7: The cycle after the final write completes, `load_done`=1, `loader_busy`=0 and `mem_we`=0.
- R8: A byte count of zero gives `load_done`=1 in the cycle after the fourth header byte, with no memory write.
- R9: After `load_done`, incoming bytes cause no write, and `load_done` stays 1.
- R10: A one-cycle `start` pulse, in any state, drops any partial header and any pending data. It clears `overrun_err` and returns to header collection, with `loader_busy`=1 and `load_done`=0 in the next cycle.
- R11: Bytes that arrive after the full count has been taken in, while writes are still pending, are ignored and do not set `overrun_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Re-arm pulse: restart header collection |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_data` |
| rx_data | input | 8 | Received serial byte |
| mem_ready | input | 1 | Memory accepts the presented write this cycle |
| mem_addr | output | 16 | Write address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write request |
| loader_busy | output | 1 | Loader owns the memory port |
| load_done | output | 1 | All counted bytes written |
| overrun_err | output | 1 | Sticky: a payload byte was lost |

## Verification
The hardest case to reach is the full condition. A write must be stalled and the one-byte buffer occupied when a third byte arrives. Here that byte must be dropped without being counted. The stimulus holds `mem_ready` low and sends three payload bytes in a row. It then releases the port and confirms the transfer does not finish until one more byte arrives. A related case, bytes beyond the count while writes are stalled, comes from a one-byte transfer followed by extra bytes during a stall.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_DATA = 2'd1,
        ST_DONE = 2'd2
    } ldr_state_e;
endpackage

// File: rtl/ldr_hdr_collect.sv
// Shifts header bytes in LSB first; flags the byte that completes the header.
module ldr_hdr_collect #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic [7:0]        byte_in,
    output logic              complete,
    output logic [ADDR_W-1:0] addr_out,
    output logic [LEN_W-1:0]  len_out
);
    localparam int HDR_BITS  = ADDR_W + LEN_W;
    localparam int HDR_BYTES = HDR_BITS / 8;
    localparam int IDX_W     = (HDR_BYTES > 2) ? $clog2(HDR_BYTES) : 1;

    typedef struct packed {
        logic [HDR_BITS-1:0] sr;
        logic [IDX_W-1:0]    idx;
    } hdr_t;

    hdr_t q, d;
    logic [HDR_BITS-1:0] shifted;

    always_comb begin
        d        = q;
        shifted  = {byte_in, q.sr[HDR_BITS-1:8]};
        complete = take && (q.idx == IDX_W'(HDR_BYTES - 1));
        if (clear) begin
            d = '0;
        end else if (take) begin
            d.sr  = shifted;
            d.idx = complete ? '0 : q.idx + IDX_W'(1);
        end
    end

    assign addr_out = shifted[ADDR_W-1:0];
    assign len_out  = shifted[HDR_BITS-1:ADDR_W];

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ldr_wr_stage.sv
// Presented write register plus a one-entry holding buffer behind it.
module ldr_wr_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              mem_ready,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data,
    output logic              fire,
    output logic              accept,
    output logic              empty_next
);
    typedef struct packed {
        logic              wr_valid;
        logic [DATA_W-1:0] wr_data;
        logic              hold_valid;
        logic [DATA_W-1:0] hold_data;
    } stage_t;

    stage_t q, d;

    always_comb begin
        d      = q;
        fire   = q.wr_valid && mem_ready;
        accept = !q.hold_valid || fire;
        if (clear) begin
            d = '0;
        end else begin
            if (fire) begin
                d.wr_valid = 1'b0;
                if (q.hold_valid) begin
                    d.wr_valid   = 1'b1;
                    d.wr_data    = q.hold_data;
                    d.hold_valid = 1'b0;
                end
            end
            if (push && accept) begin
                if (!d.wr_valid) begin
                    d.wr_valid = 1'b1;
                    d.wr_data  = push_data;
                end else begin
                    d.hold_valid = 1'b1;
                    d.hold_data  = push_data;
                end
            end
        end
        empty_next = !d.wr_valid && !d.hold_valid;
    end

    assign wr_valid = q.wr_valid;
    assign wr_data  = q.wr_data;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/serial_loader.sv
module serial_loader #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              loader_busy,
    output logic              load_done,
    output logic              overrun_err
);
    import ldr_pkg::*;

    localparam int DATA_W = 8;

    typedef struct packed {
        ldr_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
        logic              err;
    } ctl_t;

    ctl_t q, d;

    logic              hdr_take, hdr_complete;
    logic [ADDR_W-1:0] hdr_addr;
    logic [LEN_W-1:0]  hdr_len;
    logic              push, fire, accept, empty_next, wr_valid;
    logic [DATA_W-1:0] wr_data;

    assign hdr_take = rx_valid && !start && (q.state == ST_HDR);
    assign push     = rx_valid && !start && (q.state == ST_DATA) && (q.left != '0);

    ldr_hdr_collect #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .take     (hdr_take),
        .byte_in  (rx_data),
        .complete (hdr_complete),
        .addr_out (hdr_addr),
        .len_out  (hdr_len)
    );

    ldr_wr_stage #(.DATA_W(DATA_W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .push       (push),
        .push_data  (rx_data),
        .mem_ready  (mem_ready),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .fire       (fire),
        .accept     (accept),
        .empty_next (empty_next)
    );

    always_comb begin
        d = q;
        if (start) begin
            d.state = ST_HDR;
            d.left  = '0;
            d.err   = 1'b0;
        end else begin
            unique case (q.state)
                ST_HDR: begin
                    if (hdr_complete) begin
                        d.addr  = hdr_addr;
                        d.left  = hdr_len;
                        d.state = (hdr_len == '0) ? ST_DONE : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (fire)
                        d.addr = q.addr + ADDR_W'(1);
                    if (push && accept)
                        d.left = q.left - LEN_W'(1);
                    if (push && !accept)
                        d.err = 1'b1;
                    if ((d.left == '0) && empty_next)
                        d.state = ST_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= ST_HDR;
            q.addr  <= '0;
            q.left  <= '0;
            q.err   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign mem_addr    = q.addr;
    assign mem_wdata   = wr_data;
    assign mem_we      = wr_valid;
    assign load_done   = (q.state == ST_DONE);
    assign loader_busy = (q.state != ST_DONE);
    assign overrun_err = q.err;
endmodule

// File: rtl/serial_loader_checker.sv
module serial_loader_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_we,
    input logic              loader_busy,
    input logic              load_done,
    input logic              overrun_err
);
    a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_ready && !start) |=>
            (mem_we && $stable(mem_addr) && $stable(mem_wdata)));

    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ready && !start) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_err && !start) |=> overrun_err);

    a_r7_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (!mem_we && !loader_busy));

    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && !start) |=> load_done);

    a_r10_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (loader_busy && !load_done && !overrun_err && !mem_we));
endmodule

bind serial_loader serial_loader_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_we      (mem_we),
    .loader_busy (loader_busy),
    .load_done   (load_done),
    .overrun_err (overrun_err)
);

// File: tb/serial_loader_test.sv
`timescale 1ns/1ps
module serial_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        mem_ready = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, loader_busy, load_done, overrun_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [23:0] exp_q[$];
    logic [15:0] exp_addr;

    always #10 clk = ~clk;

    serial_loader uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rx_valid(rx_valid),
        .rx_data(rx_data), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .loader_busy(loader_busy),
        .load_done(load_done), .overrun_err(overrun_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: every completed write is compared with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && mem_we && mem_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected write", {mem_addr, mem_wdata}, 32'h0);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                check({mem_addr, mem_wdata} == e, "R3 write addr/data", {mem_addr, mem_wdata}, e);
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic send_hdr(input logic [15:0] a, input logic [15:0] n);
        send(a[7:0]); send(a[15:8]); send(n[7:0]); send(n[15:8]);
        exp_addr = a;
    endtask

    // Driver: sends a payload byte; pushes the expected write when it is kept
    task automatic send_pl(input logic [7:0] b, input bit kept);
        if (kept) begin
            exp_q.push_back({exp_addr, b});
            exp_addr = exp_addr + 16'd1;
        end
        send(b);
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        check(loader_busy && !load_done && !overrun_err && !mem_we, "R10 re-armed",
              {loader_busy, load_done, overrun_err, mem_we}, 4'b1000);
    endtask

    task automatic set_ready(input logic r);
        @(posedge clk); #1 mem_ready = r;
    endtask

    task automatic wait_done(input string req);
        for (int i = 0; i < 30 && !load_done; i++) @(negedge clk);
        @(negedge clk);
        check(load_done && !loader_busy && !mem_we, req,
              {load_done, loader_busy, mem_we}, 3'b100);
        check(exp_q.size() == 0, {req, " all writes seen"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(loader_busy && !load_done && !mem_we && !overrun_err, "R1 reset state",
              {loader_busy, load_done, mem_we, overrun_err}, 4'b1000);

        // R2/R3/R7: plain transfer
        send_hdr(16'h1234, 16'd3);
        send_pl(8'hA1, 1); send_pl(8'hB2, 1); send_pl(8'hC3, 1);
        wait_done("R7 done after 3 bytes R2");
        check(!overrun_err, "R6 no error on clean load", overrun_err, 0);

        // R9: bytes after done are ignored
        send(8'h55); send(8'h66); send(8'h77);
        @(negedge clk);
        check(load_done && !mem_we, "R9 ignored after done", {load_done, mem_we}, 2'b10);

        // R4/R5: stall with a buffered byte
        pulse_start();
        send_hdr(16'h8000, 16'd4);
        set_ready(1'b0);
        send_pl(8'h11, 1); send_pl(8'h22, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(mem_we && mem_addr == 16'h8000 && mem_wdata == 8'h11, "R4 stalled write held",
                  {mem_we, mem_addr, mem_wdata}, {1'b1, 16'h8000, 8'h11});
        end
        check(!overrun_err, "R5 buffered byte no error", overrun_err, 0);
        set_ready(1'b1);
        send_pl(8'h33, 1); send_pl(8'h44, 1);
        wait_done("R5 done after stall");

        // R6: overrun drops a byte that is not counted
        pulse_start();
        send_hdr(16'h0100, 16'd3);
        set_ready(1'b0);
        send_pl(8'hD0, 1); send_pl(8'hD1, 1); send_pl(8'hDE, 0);
        @(negedge clk);
        check(overrun_err, "R6 overrun flagged", overrun_err, 1);
        set_ready(1'b1);
        repeat (6) @(negedge clk);
        check(!load_done, "R6 dropped byte not counted", load_done, 0);
        send_pl(8'hD2, 1);
        wait_done("R6 done after resend");
        check(overrun_err, "R6 error sticky", overrun_err, 1);

        // R8: zero count
        pulse_start();
        send_hdr(16'h5000, 16'd0);
        @(negedge clk);
        check(load_done && !mem_we, "R8 zero count done", {load_done, mem_we}, 2'b10);

        // R3: address wrap
        pulse_start();
        send_hdr(16'hFFFE, 16'd3);
        send_pl(8'h01, 1); send_pl(8'h02, 1); send_pl(8'h03, 1);
        wait_done("R3 wrap done");

        // R11: extra bytes beyond count while write pending
        pulse_start();
        send_hdr(16'h2000, 16'd1);
        set_ready(1'b0);
        send_pl(8'h9A, 1); send_pl(8'h9B, 0); send_pl(8'h9C, 0);
        @(negedge clk);
        check(!overrun_err && mem_we, "R11 extra bytes ignored", {overrun_err, mem_we}, 2'b01);
        set_ready(1'b1);
        wait_done("R11 done single write");

        // R10: start in the middle of a header
        pulse_start();
        send(8'hEE); send(8'hEE);
        pulse_start();
        send_hdr(16'h3000, 16'd1);
        send_pl(8'h5A, 1);
        wait_done("R10 header restarted");

        finish_run();
    end
endmodule